// File: doc/BRIEF.md
# Endpoint Group Freeze Filter

This block sits between the host fabric and a PCIe link and isolates misbehaving device groups. Each transaction arrives already tagged with a group number (0 to NUM_PE-1). The block keeps a small state table holding, for every group, a flag that gates host-initiated memory-mapped accesses, a flag that gates device-initiated DMA, and an optional link to one companion group.

When a group is frozen, stores are discarded in both directions. Loads are answered locally with an all-ones completion and are never forwarded. Message-signalled interrupts from the group are suppressed. A freeze event always raises both flags together. Software lowers each flag on its own through a write port, so it can, for example, reopen register access for diagnosis while DMA stays fenced.

A freeze raised by an error message can spread to the group's companion. The spread goes one step only. A status port reads back both flags of any group.

Top module: `pff_top`

## Requirements
- R1: After reset every group has both flags clear and no companion link, so every request is forwarded.
- R2: A freeze request (`frz_vld`) for group P sets both flags of P at the next clock edge; from then on `st_mmio` and `st_dma` read 1 for P.
- R3: A software write with `cfg_clr_mmio`=1 clears only the access flag of `cfg_pe`, and `cfg_clr_dma`=1 clears only the DMA flag; the other flag keeps its value.
- R4: When a freeze and a software clear name the same group in the same cycle, both flags of that group end up set.
- R5: A store (write=1) whose group has its gating flag set is discarded: no output valid and no completion.
- R6: A load (write=0) whose group has its gating flag set is not forwarded; one cycle later the completion output is valid with every data bit 1.
- R7: An interrupt is suppressed exactly when the DMA flag of its group is set; the access flag alone does not suppress it.
- R8: Host accesses are gated only by the access flag, and DMA only by the DMA flag.
- R9: A request that is not gated appears on its output one cycle later with write flag, address and data unchanged.
- R10: A freeze with `frz_err`=1 on group P whose link is valid also sets both flags of the linked group in the same edge; a freeze with `frz_err`=0 does not spread, and the linked group's own link is not followed.
- R11: Gating uses the table as it stood before the current cycle's update, so a request in the same cycle as its group's freeze is still forwarded.
- R12: A software write with `cfg_link_wr`=1 stores `cfg_link_vld` and `cfg_link_pe` as the companion link of `cfg_pe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frz_vld | input | 1 | Freeze request |
| frz_pe | input | PE_W | Group to freeze |
| frz_err | input | 1 | Freeze caused by an error message (may spread) |
| cfg_wr | input | 1 | Software write strobe |
| cfg_pe | input | PE_W | Group addressed by the write |
| cfg_clr_mmio | input | 1 | Clear access flag |
| cfg_clr_dma | input | 1 | Clear DMA flag |
| cfg_link_wr | input | 1 | Write companion link |
| cfg_link_vld | input | 1 | New link valid bit |
| cfg_link_pe | input | PE_W | New companion group |
| st_pe | input | PE_W | Group to read status of |
| st_mmio | output | 1 | Access flag of st_pe |
| st_dma | output | 1 | DMA flag of st_pe |
| mm_vld | input | 1 | Host access valid |
| mm_pe | input | PE_W | Host access group |
| mm_wr | input | 1 | Host access is a store |
| mm_addr | input | ADDR_W | Host access address |
| mm_wdata | input | DATA_W | Host store data |
| mm_out_vld | output | 1 | Forwarded host access valid |
| mm_out_wr | output | 1 | Forwarded store flag |
| mm_out_addr | output | ADDR_W | Forwarded address |
| mm_out_wdata | output | DATA_W | Forwarded data |
| mm_cpl_vld | output | 1 | Local completion for gated load |
| mm_cpl_data | output | DATA_W | Local completion data |
| dma_vld | input | 1 | DMA request valid |
| dma_pe | input | PE_W | DMA group |
| dma_wr | input | 1 | DMA is a store |
| dma_addr | input | ADDR_W | DMA address |
| dma_wdata | input | DATA_W | DMA store data |
| dma_out_vld | output | 1 | Forwarded DMA valid |
| dma_out_wr | output | 1 | Forwarded store flag |
| dma_out_addr | output | ADDR_W | Forwarded address |
| dma_out_wdata | output | DATA_W | Forwarded data |
| dma_cpl_vld | output | 1 | Local completion for gated DMA load |
| dma_cpl_data | output | DATA_W | Local completion data |
| msi_vld | input | 1 | Interrupt message valid |
| msi_pe | input | PE_W | Interrupt group |
| msi_vec | input | VEC_W | Interrupt vector |
| msi_out_vld | output | 1 | Forwarded interrupt valid |
| msi_out_vec | output | VEC_W | Forwarded vector |

## Verification
Directed sequences cover the distinct flag combinations on one group. These are both flags set, only DMA set after an access-flag clear, and only access set after a DMA clear. Together they show whether each traffic class reads the right flag and whether interrupts follow the DMA flag. Chains of two links separate a one-step spread from a recursive one. A non-error freeze on a linked group separates a spread that depends on the cause from one that always happens. Same-cycle collisions show whether freeze wins over clear and whether gating uses the old state. Random traffic then mixes freezes, clears, link writes and requests on a few crowded group numbers, with an occasional far number. A reference table computes every output.

// File: rtl/pff_pkg.sv
package pff_pkg;

    // Two gating flags held per endpoint group
    typedef struct packed {
        logic mmio;
        logic dma;
    } frz_bits_t;

    // Decision a gate takes for the request of the current cycle
    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_PASS,
        ACT_DROP,
        ACT_ONES
    } gate_act_t;

endpackage

// File: rtl/pff_state_table.sv
module pff_state_table
    import pff_pkg::*;
#(
    parameter int NUM_PE = 256,
    parameter int NLK    = 4,
    localparam int PE_W  = $clog2(NUM_PE)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frz_vld,
    input  logic [PE_W-1:0]            frz_pe,
    input  logic                       frz_err,
    input  logic                       cfg_wr,
    input  logic [PE_W-1:0]            cfg_pe,
    input  logic                       cfg_clr_mmio,
    input  logic                       cfg_clr_dma,
    input  logic                       cfg_link_wr,
    input  logic                       cfg_link_vld,
    input  logic [PE_W-1:0]            cfg_link_pe,
    input  logic [NLK-1:0][PE_W-1:0]   lk_pe,
    output frz_bits_t [NLK-1:0]        lk_bits
);

    typedef struct packed {
        frz_bits_t         flags;
        logic              link_vld;
        logic [PE_W-1:0]   link_pe;
    } ent_t;

    typedef struct packed {
        ent_t [NUM_PE-1:0] tbl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // software side first: clears and link programming
        if (cfg_wr) begin
            if (cfg_clr_mmio) st_d.tbl[cfg_pe].flags.mmio = 1'b0;
            if (cfg_clr_dma)  st_d.tbl[cfg_pe].flags.dma  = 1'b0;
            if (cfg_link_wr) begin
                st_d.tbl[cfg_pe].link_vld = cfg_link_vld;
                st_d.tbl[cfg_pe].link_pe  = cfg_link_pe;
            end
        end
        // freeze applied last so it overrides a clear on the same group
        if (frz_vld) begin
            st_d.tbl[frz_pe].flags = '{mmio: 1'b1, dma: 1'b1};
            // one-step spread along the stored (pre-update) link
            if (frz_err && st_q.tbl[frz_pe].link_vld) begin
                st_d.tbl[st_q.tbl[frz_pe].link_pe].flags = '{mmio: 1'b1, dma: 1'b1};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NLK; g++) begin : g_lookup
        assign lk_bits[g] = st_q.tbl[lk_pe[g]].flags;
    end

    AST_FRZ_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        frz_vld |=> (st_q.tbl[$past(frz_pe)].flags.mmio && st_q.tbl[$past(frz_pe)].flags.dma)); // R2

    AST_FRZ_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_vld && cfg_wr && cfg_pe == frz_pe && cfg_clr_mmio)
        |=> st_q.tbl[$past(cfg_pe)].flags.mmio); // R4

    AST_CLR_KEEPS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_clr_mmio && !cfg_clr_dma && !frz_vld)
        |=> st_q.tbl[$past(cfg_pe)].flags.dma == $past(st_q.tbl[cfg_pe].flags.dma)); // R3

    AST_SPREAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_vld && frz_err && st_q.tbl[frz_pe].link_vld)
        |=> st_q.tbl[$past(st_q.tbl[frz_pe].link_pe)].flags.dma); // R10

endmodule

// File: rtl/pff_access_gate.sv
module pff_access_gate
    import pff_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              frozen,
    output logic              out_vld,
    output logic              out_wr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic              cpl_vld,
    output logic [DATA_W-1:0] cpl_data
);

    typedef struct packed {
        logic              out_vld;
        logic              out_wr;
        logic [ADDR_W-1:0] out_addr;
        logic [DATA_W-1:0] out_wdata;
        logic              cpl_vld;
        logic [DATA_W-1:0] cpl_data;
    } state_t;

    state_t    st_d, st_q;
    gate_act_t act;

    always_comb begin
        if (!in_vld)      act = ACT_IDLE;
        else if (!frozen) act = ACT_PASS;
        else if (in_wr)   act = ACT_DROP;
        else              act = ACT_ONES;
    end

    always_comb begin
        st_d = '0;
        unique case (act)
            ACT_PASS: begin
                st_d.out_vld   = 1'b1;
                st_d.out_wr    = in_wr;
                st_d.out_addr  = in_addr;
                st_d.out_wdata = in_wdata;
            end
            ACT_ONES: begin
                st_d.cpl_vld  = 1'b1;
                st_d.cpl_data = '1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld   = st_q.out_vld;
    assign out_wr    = st_q.out_wr;
    assign out_addr  = st_q.out_addr;
    assign out_wdata = st_q.out_wdata;
    assign cpl_vld   = st_q.cpl_vld;
    assign cpl_data  = st_q.cpl_data;

    AST_FROZEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && frozen) |=> !out_vld); // R5

    AST_LOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_vld |-> (&cpl_data)); // R6

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_vld && cpl_vld)); // R9

endmodule

// File: rtl/pff_msi_gate.sv
module pff_msi_gate #(
    parameter int VEC_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [VEC_W-1:0] in_vec,
    input  logic             dma_frozen,
    output logic             out_vld,
    output logic [VEC_W-1:0] out_vec
);

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (in_vld && !dma_frozen) begin
            st_d.vld = 1'b1;
            st_d.vec = in_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_vec = st_q.vec;

    AST_MSI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && dma_frozen) |=> !out_vld); // R7

    AST_MSI_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !dma_frozen) |=> (out_vld && out_vec == $past(in_vec))); // R9

endmodule

// File: rtl/pff_top.sv
module pff_top
    import pff_pkg::*;
#(
    parameter int NUM_PE = 256,
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64,
    parameter int VEC_W  = 11,
    localparam int PE_W  = $clog2(NUM_PE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frz_vld,
    input  logic [PE_W-1:0]   frz_pe,
    input  logic              frz_err,
    input  logic              cfg_wr,
    input  logic [PE_W-1:0]   cfg_pe,
    input  logic              cfg_clr_mmio,
    input  logic              cfg_clr_dma,
    input  logic              cfg_link_wr,
    input  logic              cfg_link_vld,
    input  logic [PE_W-1:0]   cfg_link_pe,
    input  logic [PE_W-1:0]   st_pe,
    output logic              st_mmio,
    output logic              st_dma,
    input  logic              mm_vld,
    input  logic [PE_W-1:0]   mm_pe,
    input  logic              mm_wr,
    input  logic [ADDR_W-1:0] mm_addr,
    input  logic [DATA_W-1:0] mm_wdata,
    output logic              mm_out_vld,
    output logic              mm_out_wr,
    output logic [ADDR_W-1:0] mm_out_addr,
    output logic [DATA_W-1:0] mm_out_wdata,
    output logic              mm_cpl_vld,
    output logic [DATA_W-1:0] mm_cpl_data,
    input  logic              dma_vld,
    input  logic [PE_W-1:0]   dma_pe,
    input  logic              dma_wr,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              dma_out_vld,
    output logic              dma_out_wr,
    output logic [ADDR_W-1:0] dma_out_addr,
    output logic [DATA_W-1:0] dma_out_wdata,
    output logic              dma_cpl_vld,
    output logic [DATA_W-1:0] dma_cpl_data,
    input  logic              msi_vld,
    input  logic [PE_W-1:0]   msi_pe,
    input  logic [VEC_W-1:0]  msi_vec,
    output logic              msi_out_vld,
    output logic [VEC_W-1:0]  msi_out_vec
);

    localparam int NLK    = 4;
    localparam int LK_MM  = 0;
    localparam int LK_DMA = 1;
    localparam int LK_MSI = 2;
    localparam int LK_ST  = 3;

    logic [NLK-1:0][PE_W-1:0] lk_pe;
    frz_bits_t [NLK-1:0]      lk_bits;

    always_comb begin
        lk_pe[LK_MM]  = mm_pe;
        lk_pe[LK_DMA] = dma_pe;
        lk_pe[LK_MSI] = msi_pe;
        lk_pe[LK_ST]  = st_pe;
    end

    pff_state_table #(.NUM_PE(NUM_PE), .NLK(NLK)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .frz_vld      (frz_vld),
        .frz_pe       (frz_pe),
        .frz_err      (frz_err),
        .cfg_wr       (cfg_wr),
        .cfg_pe       (cfg_pe),
        .cfg_clr_mmio (cfg_clr_mmio),
        .cfg_clr_dma  (cfg_clr_dma),
        .cfg_link_wr  (cfg_link_wr),
        .cfg_link_vld (cfg_link_vld),
        .cfg_link_pe  (cfg_link_pe),
        .lk_pe        (lk_pe),
        .lk_bits      (lk_bits)
    );

    assign st_mmio = lk_bits[LK_ST].mmio;
    assign st_dma  = lk_bits[LK_ST].dma;

    pff_access_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mm_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (mm_vld),
        .in_wr     (mm_wr),
        .in_addr   (mm_addr),
        .in_wdata  (mm_wdata),
        .frozen    (lk_bits[LK_MM].mmio),
        .out_vld   (mm_out_vld),
        .out_wr    (mm_out_wr),
        .out_addr  (mm_out_addr),
        .out_wdata (mm_out_wdata),
        .cpl_vld   (mm_cpl_vld),
        .cpl_data  (mm_cpl_data)
    );

    pff_access_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dma_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (dma_vld),
        .in_wr     (dma_wr),
        .in_addr   (dma_addr),
        .in_wdata  (dma_wdata),
        .frozen    (lk_bits[LK_DMA].dma),
        .out_vld   (dma_out_vld),
        .out_wr    (dma_out_wr),
        .out_addr  (dma_out_addr),
        .out_wdata (dma_out_wdata),
        .cpl_vld   (dma_cpl_vld),
        .cpl_data  (dma_cpl_data)
    );

    pff_msi_gate #(.VEC_W(VEC_W)) u_msi_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (msi_vld),
        .in_vec     (msi_vec),
        .dma_frozen (lk_bits[LK_MSI].dma),
        .out_vld    (msi_out_vld),
        .out_vec    (msi_out_vec)
    );

    AST_MM_IGNORES_DMA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_vld && !lk_bits[LK_MM].mmio) |=> mm_out_vld); // R8

endmodule

// File: tb/sim_pff_top.sv
module sim_pff_top;

    localparam int NUM_PE = 256;
    localparam int PE_W   = 8;
    localparam int ADDR_W = 48;
    localparam int DATA_W = 64;
    localparam int VEC_W  = 11;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst_n;
    logic              frz_vld, frz_err;
    logic [PE_W-1:0]   frz_pe;
    logic              cfg_wr, cfg_clr_mmio, cfg_clr_dma, cfg_link_wr, cfg_link_vld;
    logic [PE_W-1:0]   cfg_pe, cfg_link_pe, st_pe;
    logic              st_mmio, st_dma;
    logic              mm_vld, mm_wr;
    logic [PE_W-1:0]   mm_pe;
    logic [ADDR_W-1:0] mm_addr;
    logic [DATA_W-1:0] mm_wdata;
    logic              mm_out_vld, mm_out_wr, mm_cpl_vld;
    logic [ADDR_W-1:0] mm_out_addr;
    logic [DATA_W-1:0] mm_out_wdata, mm_cpl_data;
    logic              dma_vld, dma_wr;
    logic [PE_W-1:0]   dma_pe;
    logic [ADDR_W-1:0] dma_addr;
    logic [DATA_W-1:0] dma_wdata;
    logic              dma_out_vld, dma_out_wr, dma_cpl_vld;
    logic [ADDR_W-1:0] dma_out_addr;
    logic [DATA_W-1:0] dma_out_wdata, dma_cpl_data;
    logic              msi_vld, msi_out_vld;
    logic [PE_W-1:0]   msi_pe;
    logic [VEC_W-1:0]  msi_vec, msi_out_vec;

    pff_top u0 (.*);

    int checks = 0;
    int fails  = 0;

    // reference table
    bit              m_mmio [NUM_PE];
    bit              m_dma  [NUM_PE];
    bit              m_lv   [NUM_PE];
    bit [PE_W-1:0]   m_lp   [NUM_PE];

    // expected outputs of the pending cycle
    bit              e_mm_vld, e_mm_wr, e_mm_cpl;
    bit [ADDR_W-1:0] e_mm_addr;
    bit [DATA_W-1:0] e_mm_wdata;
    bit              e_dma_vld, e_dma_wr, e_dma_cpl;
    bit [ADDR_W-1:0] e_dma_addr;
    bit [DATA_W-1:0] e_dma_wdata;
    bit              e_msi_vld;
    bit [VEC_W-1:0]  e_msi_vec;

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic idle();
        frz_vld = 0; frz_err = 0; frz_pe = '0;
        cfg_wr = 0; cfg_pe = '0; cfg_clr_mmio = 0; cfg_clr_dma = 0;
        cfg_link_wr = 0; cfg_link_vld = 0; cfg_link_pe = '0;
        mm_vld = 0; mm_wr = 0; mm_pe = '0; mm_addr = '0; mm_wdata = '0;
        dma_vld = 0; dma_wr = 0; dma_pe = '0; dma_addr = '0; dma_wdata = '0;
        msi_vld = 0; msi_pe = '0; msi_vec = '0;
    endtask

    // expected gate result from requirement text
    function automatic bit pass_of(bit vld, bit flag);
        return vld && !flag;
    endfunction

    task automatic model_update();
        bit          olv = m_lv[frz_pe];
        bit [PE_W-1:0] olp = m_lp[frz_pe];
        if (cfg_wr) begin
            if (cfg_clr_mmio) m_mmio[cfg_pe] = 0;
            if (cfg_clr_dma)  m_dma[cfg_pe]  = 0;
            if (cfg_link_wr) begin
                m_lv[cfg_pe] = cfg_link_vld;
                m_lp[cfg_pe] = cfg_link_pe;
            end
        end
        if (frz_vld) begin
            m_mmio[frz_pe] = 1; m_dma[frz_pe] = 1;
            if (frz_err && olv) begin
                m_mmio[olp] = 1; m_dma[olp] = 1;
            end
        end
    endtask

    // one clock: called at a falling edge with inputs driven
    task automatic step();
        #1;
        chk("R2 status mmio", st_mmio, m_mmio[st_pe]);
        chk("R3 status dma", st_dma, m_dma[st_pe]);
        e_mm_vld   = pass_of(mm_vld, m_mmio[mm_pe]);
        e_mm_cpl   = mm_vld && m_mmio[mm_pe] && !mm_wr;
        e_mm_wr    = mm_wr; e_mm_addr = mm_addr; e_mm_wdata = mm_wdata;
        e_dma_vld  = pass_of(dma_vld, m_dma[dma_pe]);
        e_dma_cpl  = dma_vld && m_dma[dma_pe] && !dma_wr;
        e_dma_wr   = dma_wr; e_dma_addr = dma_addr; e_dma_wdata = dma_wdata;
        e_msi_vld  = pass_of(msi_vld, m_dma[msi_pe]);
        e_msi_vec  = msi_vec;
        model_update();
        @(posedge clk);
        @(negedge clk);
        chk("R8 mm forward", mm_out_vld, e_mm_vld);
        if (e_mm_vld) begin
            chk("R9 mm wr", mm_out_wr, e_mm_wr);
            chk("R9 mm addr", mm_out_addr, e_mm_addr);
            chk("R9 mm data", mm_out_wdata, e_mm_wdata);
        end
        chk("R6 mm cpl", mm_cpl_vld, e_mm_cpl);
        if (e_mm_cpl) chk("R6 mm ones", mm_cpl_data, {DATA_W{1'b1}});
        chk("R8 dma forward", dma_out_vld, e_dma_vld);
        if (e_dma_vld) begin
            chk("R9 dma wr", dma_out_wr, e_dma_wr);
            chk("R9 dma addr", dma_out_addr, e_dma_addr);
            chk("R9 dma data", dma_out_wdata, e_dma_wdata);
        end
        chk("R5 dma cpl", dma_cpl_vld, e_dma_cpl);
        if (e_dma_cpl) chk("R6 dma ones", dma_cpl_data, {DATA_W{1'b1}});
        chk("R7 msi", msi_out_vld, e_msi_vld);
        if (e_msi_vld) chk("R9 msi vec", msi_out_vec, e_msi_vec);
    endtask

    task automatic read_st(string tag, int pe, bit em, bit ed);
        st_pe = pe[PE_W-1:0];
        #1;
        chk({tag, " mmio"}, st_mmio, em);
        chk({tag, " dma"}, st_dma, ed);
    endtask

    task automatic freeze(int pe, bit err);
        idle(); frz_vld = 1; frz_pe = pe[PE_W-1:0]; frz_err = err; step(); idle();
    endtask

    task automatic clr(int pe, bit cm, bit cd);
        idle(); cfg_wr = 1; cfg_pe = pe[PE_W-1:0]; cfg_clr_mmio = cm; cfg_clr_dma = cd;
        step(); idle();
    endtask

    task automatic link(int pe, int to);
        idle(); cfg_wr = 1; cfg_pe = pe[PE_W-1:0]; cfg_link_wr = 1; cfg_link_vld = 1;
        cfg_link_pe = to[PE_W-1:0]; step(); idle();
    endtask

    task automatic traffic(int pe, bit wr);
        idle();
        mm_vld = 1; mm_pe = pe[PE_W-1:0]; mm_wr = wr;
        mm_addr = {$urandom, $urandom}; mm_wdata = {$urandom, $urandom};
        dma_vld = 1; dma_pe = pe[PE_W-1:0]; dma_wr = wr;
        dma_addr = {$urandom, $urandom}; dma_wdata = {$urandom, $urandom};
        msi_vld = 1; msi_pe = pe[PE_W-1:0]; msi_vec = VEC_W'($urandom);
        step(); idle();
    endtask

    function automatic logic [PE_W-1:0] rpe();
        if ($urandom % 5 == 0) return PE_W'($urandom);
        return PE_W'($urandom % 8);
    endfunction

    initial begin
        void'($urandom(32'h1F2E3D4C));
        idle(); st_pe = '0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: clean state after reset, traffic flows
        read_st("R1 pe0", 0, 0, 0);
        read_st("R1 pe255", 255, 0, 0);
        traffic(3, 0);
        chk("R1 load forwarded", mm_out_vld, 1);

        // R2: freeze sets both flags
        freeze(5, 0);
        read_st("R2 pe5", 5, 1, 1);
        // R6 / R5: loads answered with ones, stores dropped
        traffic(5, 0);
        chk("R6 load cpl", mm_cpl_vld, 1);
        chk("R6 load data", mm_cpl_data, {DATA_W{1'b1}});
        chk("R6 not fwd", mm_out_vld, 0);
        traffic(5, 1);
        chk("R5 store dropped", mm_out_vld, 0);
        chk("R5 dma store dropped", dma_out_vld, 0);
        chk("R5 no cpl", mm_cpl_vld, 0);

        // R3: clear access flag only; R8 and R7 per flag
        clr(5, 1, 0);
        read_st("R3 after mmio clear", 5, 0, 1);
        traffic(5, 1);
        chk("R8 mm passes", mm_out_vld, 1);
        chk("R8 dma still gated", dma_out_vld, 0);
        chk("R7 msi blocked", msi_out_vld, 0);
        clr(5, 0, 1);
        read_st("R3 after dma clear", 5, 0, 0);

        // R7: access flag alone does not block interrupts
        freeze(6, 0);
        clr(6, 0, 1);
        read_st("R3 pe6", 6, 1, 0);
        traffic(6, 0);
        chk("R7 msi passes", msi_out_vld, 1);
        chk("R8 mm gated", mm_cpl_vld, 1);

        // R4: freeze beats clear in the same cycle
        idle(); frz_vld = 1; frz_pe = 9; cfg_wr = 1; cfg_pe = 9;
        cfg_clr_mmio = 1; cfg_clr_dma = 1; step(); idle();
        read_st("R4 pe9", 9, 1, 1);

        // R12 / R10: one-step spread on error freeze
        link(20, 21);
        link(21, 22);
        link(30, 31);
        freeze(20, 1);
        read_st("R10 companion", 21, 1, 1);
        read_st("R10 one level", 22, 0, 0);
        freeze(30, 0);
        read_st("R10 no spread", 31, 0, 0);
        read_st("R12 source", 30, 1, 1);

        // R11: same-cycle request sees old state
        idle(); frz_vld = 1; frz_pe = 40; mm_vld = 1; mm_pe = 40; mm_wr = 0;
        mm_addr = 48'h1234; step(); idle();
        chk("R11 same cycle fwd", mm_out_vld, 1);
        traffic(40, 0);
        chk("R11 next cycle ones", mm_cpl_vld, 1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            idle();
            frz_vld = ($urandom % 6 == 0); frz_pe = rpe(); frz_err = $urandom % 2;
            cfg_wr = ($urandom % 3 == 0); cfg_pe = rpe();
            cfg_clr_mmio = $urandom % 2; cfg_clr_dma = $urandom % 2;
            cfg_link_wr = ($urandom % 3 == 0); cfg_link_vld = $urandom % 2;
            cfg_link_pe = rpe();
            st_pe = rpe();
            mm_vld = $urandom % 2; mm_pe = rpe(); mm_wr = $urandom % 2;
            mm_addr = {$urandom, $urandom}; mm_wdata = {$urandom, $urandom};
            dma_vld = $urandom % 2; dma_pe = rpe(); dma_wr = $urandom % 2;
            dma_addr = {$urandom, $urandom}; dma_wdata = {$urandom, $urandom};
            msi_vld = $urandom % 2; msi_pe = rpe(); msi_vec = VEC_W'($urandom);
            step();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule